// File: doc/BRIEF.md
# Synchronising Register File Scheduler

This block holds a register file in which every register carries a presence state, and pairs it with a set of runnable threads. Each thread owns one register context for as long as it exists. A create request claims a free context, marks every register in it as holding no data, and makes the thread runnable. The scheduler hands one runnable thread per cycle to the pipeline on the issue stream. The pipeline then presents that thread's two source register indices on the operand port.

When both sources hold data, the values are returned in the same cycle and the thread becomes runnable again on the next edge. This lets a different thread issue every cycle. When a source holds no data, the thread is parked on that register, and the register's data field records the id of the waiting thread. A later write fills the register and makes the parked thread runnable again. A terminate request frees a thread's context. The count of runnable threads is exported as a load measure, and an idle flag is raised when no thread is runnable. Both can drive clock gating or frequency scaling.

Create and issue are valid/ready streams. A create is accepted on a cycle where `crt_valid` and `crt_ready` are both high, and `crt_ready` is low only while every context is in use. An issue transfers on a cycle where `iss_valid` and `iss_ready` are both high. While `iss_ready` is low no thread leaves the runnable set, but `iss_tid` may change as threads join. The consumer takes the id shown on the transfer cycle. Writes, operand reads and terminates are never back-pressured.

Top module: `sr_sched`

## Requirements
- R1: After reset no thread is runnable: `load` is 0, `idle` is 1, `iss_valid` is 0, `crt_ready` is 1 and `crt_tid` is 0.
- R2: An accepted create takes the lowest-numbered free context, which is also the thread id. That thread is runnable from the next cycle, and `crt_ready` falls once all contexts are in use.
- R3: Every register of a newly created context holds no data: an operand read of any of its registers reports `op_ok` = 0 unless the same register is written in that cycle.
- R4: An issue transfer removes the granted thread from the runnable set, so `load` drops by one on the next cycle.
- R5: An operand read whose two sources both hold data returns them on `op_a`/`op_b` with `op_ok` = 1 in the same cycle, and the thread is runnable again on the next cycle.
- R6: An operand read with a source that holds no data parks the thread. The thread is neither counted in `load` nor offered on the issue stream until that register is written.
- R7: A write fills the addressed register. If a thread is parked on it, that thread is runnable on the next cycle, and a later read returns the written value.
- R8: A write and an operand read of the same register in the same cycle resolve in favour of the write: the read sees the written value, and the thread is not parked.
- R9: A terminate returns the thread's context to the free pool. A following create may take it again, and it comes back with every register empty.
- R10: Issue is round robin: the next grant goes to the first runnable id above the last granted id, wrapping around. With all threads runnable and `iss_ready` held high, ids are granted in ascending cyclic order, one per cycle.
- R11: `load` equals the number of runnable threads, and `idle` is high exactly when `load` is 0.
- R12: When the first source (`op_ra`) holds no data, the thread parks on it. When only the second source is empty, it parks on `op_rb`. A write to any other register does not wake it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| crt_valid | input | 1 | Create request |
| crt_ready | output | 1 | A free context exists |
| crt_tid | output | TW | Id given to the thread created on this transfer |
| iss_valid | output | 1 | A runnable thread is offered |
| iss_ready | input | 1 | Pipeline accepts the offered thread |
| iss_tid | output | TW | Offered thread id |
| op_valid | input | 1 | Operand read for an in-flight thread |
| op_tid | input | TW | Thread presenting the read |
| op_ra | input | RW | First source register index |
| op_rb | input | RW | Second source register index |
| op_ok | output | 1 | Both sources hold data; the instruction proceeds |
| op_a | output | DW | First source value |
| op_b | output | DW | Second source value |
| wr_valid | input | 1 | Register write from an execution unit |
| wr_tid | input | TW | Context written |
| wr_reg | input | RW | Register written |
| wr_data | input | DW | Write value |
| term_valid | input | 1 | Thread termination |
| term_tid | input | TW | Thread that terminates |
| load | output | LW | Number of runnable threads |
| idle | output | 1 | No runnable thread |

## Verification
The assertions assume a well-behaved pipeline. An operand read or a terminate names only a thread that has been issued and has not yet had its read or terminate. Writes target only allocated contexts. A register has at most one waiter, which holds because only the owning thread reads its context. The load-step properties also assume no other event that changes the runnable set occurs in the same cycle. The bench keeps within these rules by following each thread through create, issue, read or terminate in sequence. It holds every valid low except the one being exercised, apart from the deliberate same-cycle write-and-read case.

// File: rtl/sr_pkg.sv
package sr_pkg;
  typedef enum logic [1:0] {
    RS_EMPTY = 2'd0,
    RS_WAIT  = 2'd1,
    RS_FULL  = 2'd2
  } rstate_t;
endpackage

// File: rtl/sr_lowest_free.sv
module sr_lowest_free #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  busy,
  output logic          any_free,
  output logic [IW-1:0] idx
);
  always_comb begin
    any_free = 1'b0;
    idx      = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (!busy[k]) begin
        any_free = 1'b1;
        idx      = IW'(k);
      end
    end
  end
endmodule

// File: rtl/sr_rr_pick.sv
module sr_rr_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] last_q;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int k = N; k >= 1; k--) begin
      if (req[(int'(last_q) + k) % N]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'((int'(last_q) + k) % N);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                last_q <= IW'(N - 1);
    else if (adv && gnt_valid) last_q <= gnt_idx;
  end
endmodule

// File: rtl/sr_regctx.sv
module sr_regctx #(
  parameter int NTHR = 4,
  parameter int NREG = 4,
  parameter int DW   = 8,
  localparam int TW   = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int RW   = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int NTOT = NTHR * NREG,
  localparam int XW   = TW + RW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_en,
  input  logic [TW-1:0]        clr_ctx,
  input  logic [TW-1:0]        rd_ctx,
  input  logic [RW-1:0]        rd_ra,
  input  logic [RW-1:0]        rd_rb,
  output sr_pkg::rstate_t      st_a,
  output sr_pkg::rstate_t      st_b,
  output logic [DW-1:0]        dat_a,
  output logic [DW-1:0]        dat_b,
  input  logic                 wr_en,
  input  logic [TW-1:0]        wr_ctx,
  input  logic [RW-1:0]        wr_reg,
  input  logic [DW-1:0]        wr_data,
  output sr_pkg::rstate_t      st_w,
  output logic [DW-1:0]        dat_w,
  input  logic                 park_en,
  input  logic [TW-1:0]        park_ctx,
  input  logic [RW-1:0]        park_reg,
  input  logic [TW-1:0]        park_tid
);
  import sr_pkg::*;

  rstate_t       st_v  [NTOT];
  logic [DW-1:0] dat_v [NTOT];

  logic [XW-1:0] wr_x, park_x;
  assign wr_x   = {wr_ctx, wr_reg};
  assign park_x = {park_ctx, park_reg};

  for (genvar g = 0; g < NTOT; g++) begin : g_ent
    rstate_t       st_q;
    logic [DW-1:0] dat_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= RS_EMPTY;
        dat_q <= '0;
      end else if (clr_en && clr_ctx == TW'(g / NREG)) begin
        st_q  <= RS_EMPTY;
        dat_q <= '0;
      end else if (wr_en && wr_x == XW'(g)) begin
        st_q  <= RS_FULL;
        dat_q <= wr_data;
      end else if (park_en && park_x == XW'(g)) begin
        st_q  <= RS_WAIT;
        dat_q <= DW'(park_tid);
      end
    end
    assign st_v[g]  = st_q;
    assign dat_v[g] = dat_q;
  end

  assign st_a  = st_v[{rd_ctx, rd_ra}];
  assign st_b  = st_v[{rd_ctx, rd_rb}];
  assign dat_a = dat_v[{rd_ctx, rd_ra}];
  assign dat_b = dat_v[{rd_ctx, rd_rb}];
  assign st_w  = st_v[wr_x];
  assign dat_w = dat_v[wr_x];
endmodule

// File: rtl/sr_sched.sv
module sr_sched #(
  parameter int NTHR = 4,
  parameter int NREG = 4,
  parameter int DW   = 8,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int RW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int LW = $clog2(NTHR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          crt_valid,
  output logic          crt_ready,
  output logic [TW-1:0] crt_tid,
  output logic          iss_valid,
  input  logic          iss_ready,
  output logic [TW-1:0] iss_tid,
  input  logic          op_valid,
  input  logic [TW-1:0] op_tid,
  input  logic [RW-1:0] op_ra,
  input  logic [RW-1:0] op_rb,
  output logic          op_ok,
  output logic [DW-1:0] op_a,
  output logic [DW-1:0] op_b,
  input  logic          wr_valid,
  input  logic [TW-1:0] wr_tid,
  input  logic [RW-1:0] wr_reg,
  input  logic [DW-1:0] wr_data,
  input  logic          term_valid,
  input  logic [TW-1:0] term_tid,
  output logic [LW-1:0] load,
  output logic          idle
);
  import sr_pkg::*;

  logic [NTHR-1:0] run_q, busy_q;
  rstate_t         st_a, st_b, st_w;
  logic [DW-1:0]   dat_a, dat_b, dat_w;

  logic crt_go, iss_go, hit_a, hit_b, full_a, full_b, park_go, wake_go;
  logic [RW-1:0] park_reg;
  logic [TW-1:0] waiter;

  sr_lowest_free #(.N(NTHR)) u_free (
    .busy(busy_q), .any_free(crt_ready), .idx(crt_tid)
  );

  sr_rr_pick #(.N(NTHR)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(run_q), .adv(iss_ready),
    .gnt_valid(iss_valid), .gnt_idx(iss_tid)
  );

  assign crt_go = crt_valid && crt_ready;
  assign iss_go = iss_valid && iss_ready;

  // Write bypass: a same-cycle write to a source counts as data present.
  assign hit_a  = wr_valid && wr_tid == op_tid && wr_reg == op_ra;
  assign hit_b  = wr_valid && wr_tid == op_tid && wr_reg == op_rb;
  assign full_a = hit_a || st_a == RS_FULL;
  assign full_b = hit_b || st_b == RS_FULL;
  assign op_ok  = op_valid && full_a && full_b;
  assign op_a   = hit_a ? wr_data : dat_a;
  assign op_b   = hit_b ? wr_data : dat_b;

  assign park_go  = op_valid && !(full_a && full_b);
  assign park_reg = full_a ? op_rb : op_ra;
  assign wake_go  = wr_valid && st_w == RS_WAIT;
  assign waiter   = dat_w[TW-1:0];

  sr_regctx #(.NTHR(NTHR), .NREG(NREG), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .clr_en(crt_go), .clr_ctx(crt_tid),
    .rd_ctx(op_tid), .rd_ra(op_ra), .rd_rb(op_rb),
    .st_a(st_a), .st_b(st_b), .dat_a(dat_a), .dat_b(dat_b),
    .wr_en(wr_valid), .wr_ctx(wr_tid), .wr_reg(wr_reg), .wr_data(wr_data),
    .st_w(st_w), .dat_w(dat_w),
    .park_en(park_go), .park_ctx(op_tid), .park_reg(park_reg), .park_tid(op_tid)
  );

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic set_run, clr_run;
    assign set_run = (crt_go && crt_tid == TW'(t)) ||
                     (op_ok && op_tid == TW'(t)) ||
                     (wake_go && waiter == TW'(t));
    assign clr_run = (iss_go && iss_tid == TW'(t)) ||
                     (term_valid && term_tid == TW'(t));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q[t]  <= 1'b0;
        busy_q[t] <= 1'b0;
      end else begin
        if (set_run)      run_q[t] <= 1'b1;
        else if (clr_run) run_q[t] <= 1'b0;
        if (crt_go && crt_tid == TW'(t))              busy_q[t] <= 1'b1;
        else if (term_valid && term_tid == TW'(t))    busy_q[t] <= 1'b0;
      end
    end
  end

  always_comb begin
    load = '0;
    for (int t = 0; t < NTHR; t++) load = load + LW'(run_q[t]);
  end
  assign idle = ~|run_q;
endmodule

// File: rtl/sr_sched_chk.sv
module sr_sched_chk #(
  parameter int NTHR = 4,
  localparam int LW = $clog2(NTHR + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          crt_valid,
  input logic          crt_ready,
  input logic          iss_valid,
  input logic          iss_ready,
  input logic          op_valid,
  input logic          op_ok,
  input logic          wr_valid,
  input logic [LW-1:0] load,
  input logic          idle
);
  logic ev_crt, ev_iss, ev_res;
  assign ev_crt = crt_valid && crt_ready;
  assign ev_iss = iss_valid && iss_ready;
  assign ev_res = op_valid && op_ok;

  // R2
  create_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_crt && !ev_iss && !ev_res && !wr_valid |=> load == $past(load) + LW'(1));

  // R4
  issue_removes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_iss && !ev_crt && !ev_res && !wr_valid |=> load == $past(load) - LW'(1));

  // R5
  resume_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_res && !ev_crt && !ev_iss && !wr_valid |=> load == $past(load) + LW'(1));

  // R6
  park_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ok && !ev_crt && !ev_iss && !wr_valid |=> load == $past(load));

  always @(negedge clk) begin
    if (rst_n) begin
      // R11
      idle_load_chk: assert (idle == (load == '0));
      // R11
      offer_runnable_chk: assert (iss_valid == !idle);
    end
  end
endmodule

bind sr_sched sr_sched_chk #(.NTHR(NTHR)) u_chk (
  .clk(clk), .rst_n(rst_n), .crt_valid(crt_valid), .crt_ready(crt_ready),
  .iss_valid(iss_valid), .iss_ready(iss_ready), .op_valid(op_valid),
  .op_ok(op_ok), .wr_valid(wr_valid), .load(load), .idle(idle)
);

// File: tb/sim_sr_sched.sv
`timescale 1ns/1ps
module sim_sr_sched;
  localparam int NTHR = 4, NREG = 4, DW = 8;
  localparam int TW = 2, RW = 2, LW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic crt_valid = 0, crt_ready;
  logic [TW-1:0] crt_tid;
  logic iss_valid, iss_ready = 0;
  logic [TW-1:0] iss_tid;
  logic op_valid = 0;
  logic [TW-1:0] op_tid = 0;
  logic [RW-1:0] op_ra = 0, op_rb = 0;
  logic op_ok;
  logic [DW-1:0] op_a, op_b;
  logic wr_valid = 0;
  logic [TW-1:0] wr_tid = 0;
  logic [RW-1:0] wr_reg = 0;
  logic [DW-1:0] wr_data = 0;
  logic term_valid = 0;
  logic [TW-1:0] term_tid = 0;
  logic [LW-1:0] load;
  logic idle;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sr_sched #(.NTHR(NTHR), .NREG(NREG), .DW(DW)) u0 (.*);

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int park_of(int t);
    return (t + 1) % NREG;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 load", load, 0);
    chk("R1 idle", idle, 1);
    chk("R1 iss_valid", iss_valid, 0);
    chk("R1 crt_ready", crt_ready, 1);
    chk("R1 crt_tid", crt_tid, 0);

    // R2 allocation of the lowest free context
    crt_valid = 1;
    for (int i = 0; i < NTHR; i++) begin
      #1;
      chk("R2 crt_ready", crt_ready, 1);
      chk("R2 crt_tid", crt_tid, i);
      step();
    end
    crt_valid = 0;
    #1;
    chk("R2 full", crt_ready, 0);
    chk("R11 load all", load, NTHR);

    // R10 rotation from reset pointer, R4 load drop
    iss_ready = 1;
    for (int i = 0; i < NTHR; i++) begin
      #1;
      chk("R10 iss_valid", iss_valid, 1);
      chk("R10 iss_tid", iss_tid, i);
      chk("R4 load", load, NTHR - i);
      step();
    end
    iss_ready = 0;
    #1;
    chk("R11 idle", idle, 1);

    // R3 fresh registers empty; R6 parking
    for (int t = 0; t < NTHR; t++) begin
      op_valid = 1; op_tid = TW'(t);
      op_ra = RW'(park_of(t)); op_rb = RW'(park_of(t));
      #1;
      chk("R3 op_ok fresh", op_ok, 0);
      step();
    end
    op_valid = 0;
    chk("R6 load parked", load, 0);
    iss_ready = 1;
    #1;
    chk("R6 no issue", iss_valid, 0);
    step();
    iss_ready = 0;

    // R7 fill every register; waiter wakes on its register only
    for (int t = 0; t < NTHR; t++) begin
      for (int r = 0; r < NREG; r++) begin
        wr_valid = 1; wr_tid = TW'(t); wr_reg = RW'(r);
        wr_data = DW'(t * 16 + r + 1);
        step();
        chk("R7 wake load", load, t + ((r >= park_of(t)) ? 1 : 0));
      end
    end
    wr_valid = 0;

    // R10 rotation continues after last grant 3
    iss_ready = 1;
    for (int i = 0; i < NTHR; i++) begin
      #1;
      chk("R10 iss_tid wrap", iss_tid, i);
      step();
    end
    iss_ready = 0;

    // R9 terminate threads 1..3
    for (int t = 1; t < NTHR; t++) begin
      term_valid = 1; term_tid = TW'(t);
      step();
    end
    term_valid = 0;
    #1;
    chk("R9 crt_ready", crt_ready, 1);
    chk("R9 crt_tid", crt_tid, 1);

    // R5 sweep over all source pairs of thread 0
    for (int ra = 0; ra < NREG; ra++) begin
      for (int rb = 0; rb < NREG; rb++) begin
        op_valid = 1; op_tid = 0; op_ra = RW'(ra); op_rb = RW'(rb);
        #1;
        chk("R5 op_ok", op_ok, 1);
        chk("R5 op_a", op_a, ra + 1);
        chk("R5 op_b", op_b, rb + 1);
        step();
        op_valid = 0;
        chk("R5 requeued", load, 1);
        iss_ready = 1;
        #1;
        chk("R4 iss_tid", iss_tid, 0);
        step();
        iss_ready = 0;
        chk("R4 load", load, 0);
      end
    end

    // R9 reuse of context 0 comes back empty
    term_valid = 1; term_tid = 0;
    step();
    term_valid = 0;
    #1;
    chk("R9 crt_tid reuse", crt_tid, 0);
    crt_valid = 1;
    step();
    crt_valid = 0;
    chk("R9 load", load, 1);
    wr_valid = 1; wr_tid = 0; wr_reg = 0; wr_data = 8'h55;
    step();
    wr_valid = 0;
    chk("R7 no waiter", load, 1);
    iss_ready = 1;
    step();
    iss_ready = 0;
    op_valid = 1; op_tid = 0; op_ra = 0; op_rb = 1;
    #1;
    chk("R3 reused empty", op_ok, 0);
    step();
    op_valid = 0;
    wr_valid = 1; wr_reg = 2; wr_data = 8'h44;
    step();
    chk("R12 other reg no wake", load, 0);
    wr_reg = 1; wr_data = 8'h66;
    step();
    wr_valid = 0;
    chk("R12 wake on op_rb", load, 1);
    iss_ready = 1;
    step();
    iss_ready = 0;
    op_valid = 1; op_ra = 1; op_rb = 0;
    #1;
    chk("R7 op_ok", op_ok, 1);
    chk("R7 data", op_a, 8'h66);
    step();
    op_valid = 0;
    iss_ready = 1;
    step();
    iss_ready = 0;

    // R8 write wins over same-cycle read
    op_valid = 1; op_ra = 3; op_rb = 2;
    wr_valid = 1; wr_tid = 0; wr_reg = 3; wr_data = 8'h77;
    #1;
    chk("R8 op_ok", op_ok, 1);
    chk("R8 op_a", op_a, 8'h77);
    chk("R8 op_b", op_b, 8'h44);
    step();
    op_valid = 0; wr_valid = 0;
    chk("R8 not parked", load, 1);

    // R2 fill remaining contexts, R10 order after last grant 0
    crt_valid = 1;
    for (int i = 1; i < NTHR; i++) begin
      #1;
      chk("R2 crt_tid", crt_tid, i);
      step();
    end
    crt_valid = 0;
    #1;
    chk("R2 full again", crt_ready, 0);
    chk("R11 load", load, NTHR);
    iss_ready = 1;
    for (int i = 1; i <= NTHR; i++) begin
      #1;
      chk("R10 order", iss_tid, i % NTHR);
      step();
    end
    iss_ready = 0;
    chk("R11 idle end", idle, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule